// File: doc/BRIEF.md
# Indirect Configuration Access Port Decoder

This block turns accesses on a small I/O slave bus into accesses to per-device configuration register files. The host first writes a 32-bit selector word through a four-byte address window. That word names a bus, a device, a function and a register word, and it carries a global enable bit. Later reads and writes in a second four-byte data window go to the selected device register as a word index plus a starting byte lane and an access size. The device register files sit downstream. They return the full 32-bit word and, for writes, a flag that says whether they take the write.

Only bus 0, function 0 and the first 64 bytes of each device header can be reached. A present-mask marks which device slots are fitted. An access that nothing claims reads as all ones. A data-window write that goes nowhere, or that a device refuses, raises a one-cycle error pulse. The block does not hold device register contents and does not decode host instructions.

Top module: `cfg_port_decoder`

## Requirements
- R1: The address window is I/O ports 0xCF8..0xCFB. Port bits 1:0 give the starting byte lane. A write stores only bytes lane .. lane+size-1 of the selector word, taken from the low bytes of the write value. The other bytes keep their values, and bytes past byte 3 are dropped.
- R2: A read of the address window returns the selector word shifted right by lane×8 and masked to the access size.
- R3: Size encoding on `io_size`: 0 means 1 byte (mask 0xFF), 1 means 2 bytes (0xFFFF), and 2 or 3 means 4 bytes (0xFFFFFFFF).
- R4: Selector fields: bit 31 is enable, bits 23:16 are bus, bits 15:11 are device, bits 10:8 are function, and bits 7:2 are the register word. A data-window access (ports 0xCFC..0xCFF) selects a device only when enable is 1, bus is 0, function is 0, word is below 16, and `dev_present[device]` is 1. When it does, `dev_valid` is high in the same cycle with `dev_num` equal to the device field and `dev_word` equal to the word field.
- R5: A read that no target claims returns all ones masked to the access size. This covers ports outside both windows and data-window reads that select no device.
- R6: A selecting data-window read returns `dev_rdata` shifted right by lane×8 and masked to the access size, in the same cycle.
- R7: `io_err` pulses high for exactly the cycle after a data-window write strobe that selects no device, or whose device drives `dev_accept` low.
- R8: Address-window writes never raise `io_err`. Writes to ports outside both windows raise no error and leave the selector word unchanged.
- R9: On a selecting data-window write, `dev_wr` is high and `dev_wdata`, `dev_lane` and `dev_size` carry the unshifted write value, port bits 1:0 and `io_size`.
- R10: After reset the selector word is 0 and `io_err` is low.
- R11: Selector bits 30:24 and 1:0 are stored and read back as written and have no effect on selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_valid | input | 1 | Access strobe, one cycle per access |
| io_write | input | 1 | 1 = write, 0 = read |
| io_port | input | 16 | I/O port address |
| io_size | input | 2 | Access size code (R3) |
| io_wdata | input | 32 | Write value, low-aligned |
| io_rdata | output | 32 | Read result, valid in the strobe cycle |
| io_err | output | 1 | Rejected data-window write, one cycle late |
| dev_present | input | 32 | One bit per fitted device slot |
| dev_valid | output | 1 | A device register is selected |
| dev_wr | output | 1 | Selected access is a write |
| dev_num | output | 5 | Selected device slot |
| dev_word | output | 6 | Register word index in the header |
| dev_lane | output | 2 | Starting byte lane |
| dev_size | output | 2 | Access size code |
| dev_wdata | output | 32 | Write value, unshifted |
| dev_rdata | input | 32 | Full register word from the selected device |
| dev_accept | input | 1 | Device takes the write |

## Verification
The assertions check on every cycle that an error pulse only follows a data-window write, that refused writes always raise it, that address-window writes never do, that unclaimed reads return the size mask, and that a full-word selector load is stored as written. Only the bench scenarios can show the lane arithmetic for partial and overhanging writes and reads, each filter condition (enable, bus, function, word limit, empty slot) on its own, and that reserved selector bits are kept but ignored. The bench compares the outputs against a byte-wise behavioural model on every access.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    localparam int WORD_W = 32;

    // Selector word, MSB first; bit positions are decoded by the match logic
    typedef struct packed {
        logic       en;
        logic [6:0] rsvd;
        logic [7:0] bus;
        logic [4:0] dev;
        logic [2:0] fn;
        logic [5:0] word;
        logic [1:0] low;
    } sel_word_t;

    typedef struct packed {
        logic err;
    } dec_state_t;

    function automatic logic [WORD_W-1:0] size_mask(input logic [1:0] size);
        logic [WORD_W-1:0] m;
        case (size)
            2'd0:    m = 32'h0000_00FF;
            2'd1:    m = 32'h0000_FFFF;
            default: m = 32'hFFFF_FFFF;
        endcase
        return m;
    endfunction

    function automatic logic [WORD_W-1:0] lane_merge(
        input logic [WORD_W-1:0] old,
        input logic [WORD_W-1:0] val,
        input logic [1:0]        lane,
        input logic [1:0]        size
    );
        logic [WORD_W-1:0] m;
        logic [WORD_W-1:0] sm;
        m  = size_mask(size);
        sm = m << {lane, 3'b000};
        return (old & ~sm) | ((val & m) << {lane, 3'b000});
    endfunction

    function automatic logic [WORD_W-1:0] lane_extract(
        input logic [WORD_W-1:0] word,
        input logic [1:0]        lane,
        input logic [1:0]        size
    );
        return (word >> {lane, 3'b000}) & size_mask(size);
    endfunction

endpackage

// File: rtl/cfgp_sel_reg.sv
module cfgp_sel_reg
    import cfgp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        lane,
    input  logic [1:0]        size,
    input  logic [WORD_W-1:0] wdata,
    output sel_word_t         sel_q
);

    sel_word_t sel_d;

    always_comb begin
        sel_d = sel_q;
        if (wr_en) begin
            sel_d = sel_word_t'(lane_merge(WORD_W'(sel_q), wdata, lane, size));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else begin
            sel_q <= sel_d;
        end
    end

    // R1
    full_word_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && lane == 2'd0 && size[1]) |=> (WORD_W'(sel_q) == $past(wdata)));

endmodule

// File: rtl/cfgp_match.sv
module cfgp_match #(
    parameter int N_SLOTS   = 32,
    parameter int HDR_BYTES = 64
) (
    input  logic               en,
    input  logic [7:0]         bus,
    input  logic [2:0]         fn,
    input  logic [4:0]         dev,
    input  logic [5:0]         word,
    input  logic [N_SLOTS-1:0] present,
    output logic               hit
);

    localparam logic [6:0] WORD_LIMIT = 7'(HDR_BYTES / 4);

    logic [31:0] pres_ext;
    logic        fields_ok;

    always_comb begin
        pres_ext = '0;
        pres_ext[N_SLOTS-1:0] = present;
    end

    always_comb begin
        fields_ok = en && (bus == 8'd0) && (fn == 3'd0) && ({1'b0, word} < WORD_LIMIT);
        hit       = fields_ok && pres_ext[dev];
    end

endmodule

// File: rtl/cfgp_read_mux.sv
module cfgp_read_mux
    import cfgp_pkg::*;
(
    input  logic              is_addr,
    input  logic              claim,
    input  logic [WORD_W-1:0] sel_word,
    input  logic [WORD_W-1:0] dev_word,
    input  logic [1:0]        lane,
    input  logic [1:0]        size,
    output logic [WORD_W-1:0] rdata
);

    always_comb begin
        if (is_addr) begin
            rdata = lane_extract(sel_word, lane, size);
        end else if (claim) begin
            rdata = lane_extract(dev_word, lane, size);
        end else begin
            rdata = size_mask(size);
        end
    end

endmodule

// File: rtl/cfg_port_decoder.sv
module cfg_port_decoder
    import cfgp_pkg::*;
#(
    parameter int              PORT_W    = 16,
    parameter logic [PORT_W-1:0] ADDR_PORT = 16'hCF8,
    parameter logic [PORT_W-1:0] DATA_PORT = 16'hCFC,
    parameter int              N_SLOTS   = 32,
    parameter int              HDR_BYTES = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               io_valid,
    input  logic               io_write,
    input  logic [PORT_W-1:0]  io_port,
    input  logic [1:0]         io_size,
    input  logic [31:0]        io_wdata,
    output logic [31:0]        io_rdata,
    output logic               io_err,
    input  logic [N_SLOTS-1:0] dev_present,
    output logic               dev_valid,
    output logic               dev_wr,
    output logic [4:0]         dev_num,
    output logic [5:0]         dev_word,
    output logic [1:0]         dev_lane,
    output logic [1:0]         dev_size,
    output logic [31:0]        dev_wdata,
    input  logic [31:0]        dev_rdata,
    input  logic               dev_accept
);

    localparam int WIN_W = PORT_W - 2;

    logic       is_addr;
    logic       is_data;
    logic       hit;
    logic [1:0] lane;
    sel_word_t  sel_q;
    dec_state_t st_d;
    dec_state_t st_q;

    assign lane    = io_port[1:0];
    assign is_addr = (io_port[PORT_W-1:2] == ADDR_PORT[PORT_W-1:2]);
    assign is_data = (io_port[PORT_W-1:2] == DATA_PORT[PORT_W-1:2]);

    cfgp_sel_reg u_sel (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (io_valid && io_write && is_addr),
        .lane  (lane),
        .size  (io_size),
        .wdata (io_wdata),
        .sel_q (sel_q)
    );

    cfgp_match #(
        .N_SLOTS   (N_SLOTS),
        .HDR_BYTES (HDR_BYTES)
    ) u_match (
        .en      (sel_q.en),
        .bus     (sel_q.bus),
        .fn      (sel_q.fn),
        .dev     (sel_q.dev),
        .word    (sel_q.word),
        .present (dev_present),
        .hit     (hit)
    );

    cfgp_read_mux u_rmux (
        .is_addr  (is_addr),
        .claim    (is_data && hit),
        .sel_word (WORD_W'(sel_q)),
        .dev_word (dev_rdata),
        .lane     (lane),
        .size     (io_size),
        .rdata    (io_rdata)
    );

    always_comb begin
        dev_valid = io_valid && is_data && hit;
        dev_wr    = dev_valid && io_write;
        dev_num   = sel_q.dev;
        dev_word  = sel_q.word;
        dev_lane  = lane;
        dev_size  = io_size;
        dev_wdata = io_wdata;
    end

    always_comb begin
        st_d     = st_q;
        st_d.err = io_valid && io_write && is_data && !(hit && dev_accept);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign io_err = st_q.err;

    // R7
    err_after_data_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_err |-> $past(io_valid && io_write && (io_port[PORT_W-1:2] == DATA_PORT[PORT_W-1:2])));

    // R7
    refused_write_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_wr && !dev_accept) |=> io_err);

    // R8
    addr_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_valid && io_write && (io_port[PORT_W-1:2] == ADDR_PORT[PORT_W-1:2])) |=> !io_err);

    // R5
    unclaimed_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_valid && !io_write && !is_addr && !dev_valid) |-> (io_rdata == size_mask(io_size)));

    // R4
    select_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_valid |-> (io_valid && io_port[PORT_W-1:2] == WIN_W'(DATA_PORT >> 2)));

endmodule

// File: tb/cfg_port_decoder_tb.sv
`timescale 1ns/1ps
module cfg_port_decoder_tb;

    localparam logic [31:0] SLOTS     = 32'h8000_00FF;
    localparam int          REFUSE_WD = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_valid = 1'b0;
    logic        io_write = 1'b0;
    logic [15:0] io_port = '0;
    logic [1:0]  io_size = '0;
    logic [31:0] io_wdata = '0;
    logic [31:0] io_rdata;
    logic        io_err;
    logic        dev_valid, dev_wr;
    logic [4:0]  dev_num;
    logic [5:0]  dev_word;
    logic [1:0]  dev_lane, dev_size;
    logic [31:0] dev_wdata, dev_rdata;
    logic        dev_accept;

    int checks = 0;
    int errors = 0;
    logic [31:0] m_sel = '0;

    always #4 clk = ~clk;

    // Device environment: word content derived from its identity; one word refuses writes
    assign dev_rdata  = {8'hC0, 3'b000, dev_num, 2'b00, dev_word, 8'h5A};
    assign dev_accept = (int'(dev_word) != REFUSE_WD);

    cfg_port_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_write(io_write),
        .io_port(io_port), .io_size(io_size), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .io_err(io_err), .dev_present(SLOTS),
        .dev_valid(dev_valid), .dev_wr(dev_wr), .dev_num(dev_num),
        .dev_word(dev_word), .dev_lane(dev_lane), .dev_size(dev_size),
        .dev_wdata(dev_wdata), .dev_rdata(dev_rdata), .dev_accept(dev_accept)
    );

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int nbytes(input logic [1:0] sz);
        if (sz == 2'd0) return 1;
        if (sz == 2'd1) return 2;
        return 4;
    endfunction

    function automatic logic [31:0] pick_bytes(input logic [31:0] w, input int lane, input int n);
        logic [31:0] r = '0;
        for (int b = 0; b < 4; b++) begin
            if (b >= lane && b < lane + n) r[(b-lane)*8 +: 8] = w[b*8 +: 8];
        end
        for (int b = 0; b < 4; b++) begin
            if (b >= n) r[b*8 +: 8] = 8'h00;
        end
        return r;
    endfunction

    function automatic logic [31:0] ones(input int n);
        logic [31:0] r = '0;
        for (int b = 0; b < n; b++) r[b*8 +: 8] = 8'hFF;
        return r;
    endfunction

    function automatic bit model_hit();
        return m_sel[31] && m_sel[23:16] == 8'd0 && m_sel[10:8] == 3'd0
               && m_sel[7:2] < 6'd16 && SLOTS[m_sel[15:11]];
    endfunction

    function automatic logic [31:0] model_dev_word();
        return {8'hC0, 3'b000, m_sel[15:11], 2'b00, m_sel[7:2], 8'h5A};
    endfunction

    task automatic access(input bit wr, input logic [15:0] port, input logic [1:0] sz,
                          input logic [31:0] data, input string tag);
        int  lane = int'(port[1:0]);
        int  n    = nbytes(sz);
        bit  is_a = (port >= 16'hCF8 && port <= 16'hCFB);
        bit  is_d = (port >= 16'hCFC && port <= 16'hCFF);
        bit  hit  = model_hit();
        bit  e_valid = is_d && hit;
        bit  e_err;
        logic [31:0] e_rd;
        if (is_a)         e_rd = pick_bytes(m_sel, lane, n);
        else if (e_valid) e_rd = pick_bytes(model_dev_word(), lane, n);
        else              e_rd = ones(n);
        e_err = wr && is_d && !(hit && int'(m_sel[7:2]) != REFUSE_WD);
        @(negedge clk);
        io_valid = 1'b1; io_write = wr; io_port = port; io_size = sz; io_wdata = data;
        #1;
        chk(dev_valid == e_valid, {tag, " R4 dev_valid"}, 32'(dev_valid), 32'(e_valid));
        if (e_valid) begin
            chk(dev_num == m_sel[15:11] && dev_word == m_sel[7:2], {tag, " R4 dev/word"},
                {19'd0, dev_num, 2'd0, dev_word}, {19'd0, m_sel[15:11], 2'd0, m_sel[7:2]});
            chk(dev_wr == wr, {tag, " R9 dev_wr"}, 32'(dev_wr), 32'(wr));
            if (wr) begin
                chk(dev_wdata == data && dev_lane == port[1:0] && dev_size == sz,
                    {tag, " R9 forward"}, dev_wdata, data);
            end
        end
        if (!wr) chk(io_rdata == e_rd, {tag, " R2/R5/R6 rdata"}, io_rdata, e_rd);
        @(posedge clk);
        if (wr && is_a) begin
            for (int b = 0; b < 4; b++) begin
                if (b >= lane && b < lane + n) m_sel[b*8 +: 8] = data[(b-lane)*8 +: 8];
            end
        end
        #1;
        chk(io_err == e_err, {tag, " R7/R8 io_err"}, 32'(io_err), 32'(e_err));
        io_valid = 1'b0; io_write = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R10 reset state
        chk(io_err == 1'b0, "R10 err after reset", 32'(io_err), 32'd0);
        access(0, 16'hCF8, 2'd2, 0, "R10 selector zero");

        // R1/R2 full load and lane reads
        access(1, 16'hCF8, 2'd2, 32'h8000_0810, "R1 load");
        access(0, 16'hCF8, 2'd2, 0, "R2 full");
        access(0, 16'hCF9, 2'd0, 0, "R2 byte1");
        access(0, 16'hCFA, 2'd1, 0, "R2 half hi");
        access(0, 16'hCFB, 2'd2, 0, "R2 overhang");
        // R3 size 3 acts as 4 bytes
        access(0, 16'hCF8, 2'd3, 0, "R3 size3");
        // R1 partial write keeps other bytes
        access(1, 16'hCF9, 2'd0, 32'hFFFF_FF10, "R1 byte write");
        access(0, 16'hCF8, 2'd2, 0, "R1 after byte");
        access(1, 16'hCFA, 2'd2, 32'h1234_0000, "R1 overhang write");
        access(0, 16'hCF8, 2'd2, 0, "R1 after overhang");

        // R6 data reads, several sizes and lanes
        access(1, 16'hCF8, 2'd2, 32'h8000_0810, "R6 setup");
        access(0, 16'hCFC, 2'd2, 0, "R6 word");
        access(0, 16'hCFD, 2'd0, 0, "R6 byte");
        access(0, 16'hCFE, 2'd1, 0, "R6 half");
        // R9/R7 accepted write, refused write
        access(1, 16'hCFD, 2'd0, 32'h0000_00A5, "R9 accepted");
        access(1, 16'hCF8, 2'd2, 32'h8000_0804, "R7 refuse setup");
        access(1, 16'hCFC, 2'd2, 32'h1, "R7 refused");

        // R4 filters, each alone
        access(1, 16'hCF8, 2'd2, 32'h0000_0810, "R4 enable off");
        access(0, 16'hCFC, 2'd2, 0, "R5 enable off read");
        access(1, 16'hCFC, 2'd1, 32'h7, "R7 miss write");
        access(1, 16'hCF8, 2'd2, 32'h8001_0810, "R4 bus");
        access(0, 16'hCFC, 2'd2, 0, "R4 bus read");
        access(1, 16'hCF8, 2'd2, 32'h8000_0910, "R4 fn");
        access(0, 16'hCFC, 2'd0, 0, "R4 fn read");
        access(1, 16'hCF8, 2'd2, 32'h8000_0840, "R4 word16");
        access(0, 16'hCFC, 2'd2, 0, "R4 word16 read");
        access(1, 16'hCF8, 2'd2, 32'h8000_083C, "R4 word15");
        access(0, 16'hCFC, 2'd2, 0, "R4 word15 read");
        access(1, 16'hCF8, 2'd2, 32'h8000_4000, "R4 empty slot");
        access(0, 16'hCFC, 2'd2, 0, "R4 empty read");
        access(1, 16'hCF8, 2'd2, 32'h8000_F800, "R4 slot31");
        access(0, 16'hCFC, 2'd2, 0, "R4 slot31 read");

        // R11 reserved bits kept and ignored
        access(1, 16'hCF8, 2'd2, 32'hFF00_0813, "R11 reserved");
        access(0, 16'hCF8, 2'd2, 0, "R11 readback");
        access(0, 16'hCFC, 2'd2, 0, "R11 still selects");

        // R8 other ports ignored
        access(1, 16'h0080, 2'd2, 32'hDEAD_BEEF, "R8 other write");
        access(1, 16'hCF7, 2'd2, 32'h0, "R8 below window");
        access(0, 16'hCF8, 2'd2, 0, "R8 selector kept");
        access(0, 16'hD00, 2'd1, 0, "R5 other read");

        // Mixed sequence
        for (int i = 0; i < 600; i++) begin
            int          r = int'($urandom % 10);
            logic [15:0] p;
            logic [31:0] d;
            if (r < 4)       p = 16'hCF8 + 16'(r);
            else if (r < 8)  p = 16'hCFC + 16'(r - 4);
            else if (r == 8) p = 16'h0080;
            else             p = 16'hD00;
            d = $urandom;
            if (r < 4 && ($urandom % 4) != 0) begin
                d[31] = 1'b1;
                if (($urandom % 4) != 0) d[23:16] = 8'd0;
                if (($urandom % 4) != 0) d[10:8]  = 3'd0;
                d[7:2] = 6'($urandom % 20);
            end
            access(bit'($urandom % 2), p, 2'($urandom % 4), d, "mix");
        end

        summary();
    end

endmodule